// File: doc/BRIEF.md
# E1 Signaling Change Interrupt Unit

This block watches the channel-associated ABCD signaling nibbles received on an E1 link and tells the host which timeslots changed their signaling within the last multiframe. Each time the receive path delivers a nibble for a timeslot, the unit compares it with the nibble last seen on that timeslot. A difference records the new value and marks that timeslot in a change window. At every multiframe boundary the window is copied into a host-visible snapshot and then starts again empty.

Each detected change also sets a single "signaling updated" status bit, but only while two enables are 1: the signaling-change enable and the framer-level block enable. The status bit stays set until the host clears it. A control bit selects how the host clears it: a read of the status register, or a write of 1 to it. A registered, active-high, level interrupt line reports the status bit while both enables are 1.

The host reaches everything through a simple single-cycle read/write port with registered read data. Framing, multiframe alignment, extraction of the signaling timeslot and debouncing are done upstream of this block.

Top module: `sigchg_irq_unit`

## Requirements
- R1: A strobe on a signaling timeslot whose nibble differs from that timeslot's stored nibble marks the timeslot as changed and stores the new nibble. A strobe that repeats the stored nibble marks nothing and sets no status.
- R2: Strobes on timeslot 0 and timeslot 16 carry no signaling. They are ignored: no change flag, no status.
- R3: On a boundary pulse the change window moves into the snapshot registers and the window clears. Snapshot register 0x08+k bit j shows timeslot 8k+j. A change in the same cycle as the pulse belongs to the new window.
- R4: The status bit (offset 0x04 bit 0) sets on a change only when the signaling-change enable (offset 0x05 bit 0) and the block enable (offset 0x00 bit 0) are both 1.
- R5: Once set, the status bit stays at 1 until the host clears it.
- R6: With clear-on-read selected (offset 0x06 bit 0 = 1), a read of 0x04 returns 1 and then clears the bit. Writes to 0x04 do not change it in this mode.
- R7: With offset 0x06 bit 0 = 0, reads leave the status bit unchanged. A write to 0x04 with bit 0 = 1 clears it.
- R8: A change that occurs in the same cycle as a host clear wins, and the status bit stays 1.
- R9: `irq` is registered and equals status AND both enables from the cycle before. Clearing the block enable drops `irq` one cycle later while the status bit is kept.
- R10: After reset, all stored nibbles, change flags, snapshot bits, status, control and enable bits are 0, and `irq` is 0.
- R11: Read data is registered and valid in the cycle after `host_rd`. The enable and control registers read back the value written to bit 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_valid | input | 1 | Signaling nibble strobe |
| sig_ts | input | 5 | Timeslot of the strobed nibble |
| sig_abcd | input | 4 | Received ABCD nibble |
| mf_pulse | input | 1 | Multiframe boundary pulse |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench drives a change in the same cycle as a boundary pulse. A design that files that change into the closing window shows it one multiframe too early. It clears the status bit with a read or a write in the same cycle as a fresh change, where a design with the wrong priority loses the event. It strobes the two non-signaling timeslots and repeats stored nibbles, which a careless comparator would report as changes. It also checks both clear modes against the wrong kind of access, and toggles each enable separately to catch a design that gates only one level or gates the interrupt line but not the status bit.

// File: rtl/sigchg_pkg.sv
package sigchg_pkg;

    localparam int SC_TS_COUNT = 32;
    localparam int SC_NIB_W    = 4;
    localparam int SC_DATA_W   = 8;
    localparam int SC_ADDR_W   = 8;

    // Timeslots that carry no channel-associated signaling
    localparam int SC_SKIP_TS_A = 0;
    localparam int SC_SKIP_TS_B = 16;

    // Register offsets
    localparam logic [SC_ADDR_W-1:0] OFF_BLK_EN   = 8'h00;
    localparam logic [SC_ADDR_W-1:0] OFF_STATUS   = 8'h04;
    localparam logic [SC_ADDR_W-1:0] OFF_SIG_EN   = 8'h05;
    localparam logic [SC_ADDR_W-1:0] OFF_CTRL     = 8'h06;
    localparam logic [SC_ADDR_W-1:0] OFF_CHG_BASE = 8'h08;

endpackage

// File: rtl/sigchg_detect.sv
module sigchg_detect #(
    parameter int TS_COUNT = sigchg_pkg::SC_TS_COUNT,
    parameter int NIB_W    = sigchg_pkg::SC_NIB_W,
    parameter int SKIP_A   = sigchg_pkg::SC_SKIP_TS_A,
    parameter int SKIP_B   = sigchg_pkg::SC_SKIP_TS_B,
    localparam int TS_W    = $clog2(TS_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sig_valid,
    input  logic [TS_W-1:0]     sig_ts,
    input  logic [NIB_W-1:0]    sig_nib,
    input  logic                mf_pulse,
    output logic                chg_evt,
    output logic [TS_COUNT-1:0] snapshot
);

    typedef struct packed {
        logic [TS_COUNT-1:0][NIB_W-1:0] nib;
        logic [TS_COUNT-1:0]            win;
        logic [TS_COUNT-1:0]            snap;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [TS_COUNT-1:0] hit;

    // Per-timeslot compare; the two non-signaling slots never hit
    for (genvar i = 0; i < TS_COUNT; i++) begin : g_ts
        if (i == SKIP_A || i == SKIP_B) begin : g_skip
            assign hit[i] = 1'b0;
        end else begin : g_cmp
            assign hit[i] = sig_valid
                         && (sig_ts == TS_W'(i))
                         && (sig_nib != st_q.nib[i]);
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < TS_COUNT; i++) begin
            if (hit[i]) begin
                st_d.nib[i] = sig_nib;
            end
        end
        if (mf_pulse) begin
            st_d.snap = st_q.win;
            st_d.win  = hit;
        end else begin
            st_d.win  = st_q.win | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chg_evt  = |hit;
    assign snapshot = st_q.snap;

    AST_SKIP_TS: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_valid && (sig_ts == TS_W'(SKIP_A) || sig_ts == TS_W'(SKIP_B))) |-> !chg_evt); // R2
    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mf_pulse && !sig_valid) |=> (st_q.win == '0)); // R3
    AST_SNAP_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        mf_pulse |=> (snapshot == $past(st_q.win))); // R3
    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_pulse |=> $stable(snapshot)); // R3

endmodule

// File: rtl/sigchg_regs.sv
module sigchg_regs #(
    parameter int TS_COUNT = sigchg_pkg::SC_TS_COUNT,
    parameter int DATA_W   = sigchg_pkg::SC_DATA_W,
    parameter int ADDR_W   = sigchg_pkg::SC_ADDR_W,
    localparam int CHG_REGS = TS_COUNT / DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_rd,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                chg_evt,
    input  logic [TS_COUNT-1:0] snapshot,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                irq
);
    import sigchg_pkg::*;

    typedef struct packed {
        logic              blk_en;
        logic              sig_en;
        logic              ror;
        logic              status;
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } reg_state_t;

    reg_state_t        st_d, st_q;
    logic              set_req;
    logic              clr_req;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^host_wdata[DATA_W-1:1];

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (host_addr)
            OFF_BLK_EN: rd_mux[0] = st_q.blk_en;
            OFF_STATUS: rd_mux[0] = st_q.status;
            OFF_SIG_EN: rd_mux[0] = st_q.sig_en;
            OFF_CTRL:   rd_mux[0] = st_q.ror;
            default:    rd_mux    = '0;
        endcase
        for (int k = 0; k < CHG_REGS; k++) begin
            if (host_addr == OFF_CHG_BASE + ADDR_W'(k)) begin
                rd_mux = snapshot[k*DATA_W +: DATA_W];
            end
        end
    end

    assign set_req = chg_evt && st_q.sig_en && st_q.blk_en;
    assign clr_req = (host_rd && host_addr == OFF_STATUS && st_q.ror)
                  || (host_wr && host_addr == OFF_STATUS && !st_q.ror && host_wdata[0]);

    always_comb begin
        st_d = st_q;
        if (host_wr) begin
            if (host_addr == OFF_BLK_EN) st_d.blk_en = host_wdata[0];
            if (host_addr == OFF_SIG_EN) st_d.sig_en = host_wdata[0];
            if (host_addr == OFF_CTRL)   st_d.ror    = host_wdata[0];
        end
        if (host_rd) begin
            st_d.rdata = rd_mux;
        end
        // New event takes priority over a clear in the same cycle
        if (set_req) begin
            st_d.status = 1'b1;
        end else if (clr_req) begin
            st_d.status = 1'b0;
        end
        st_d.irq = st_q.status && st_q.sig_en && st_q.blk_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;
    assign irq        = st_q.irq;

    AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.status && !(st_q.sig_en && st_q.blk_en)) |=> !st_q.status); // R4
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status && !clr_req) |=> st_q.status); // R5
    AST_ROR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFF_STATUS && st_q.ror && !chg_evt) |=> !st_q.status); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_evt && st_q.sig_en && st_q.blk_en) |=> st_q.status); // R8
    AST_IRQ_BLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.blk_en |=> !irq); // R9
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.status |=> !irq); // R9

endmodule

// File: rtl/sigchg_irq_unit.sv
module sigchg_irq_unit #(
    parameter int TS_COUNT = sigchg_pkg::SC_TS_COUNT,
    parameter int NIB_W    = sigchg_pkg::SC_NIB_W,
    parameter int DATA_W   = sigchg_pkg::SC_DATA_W,
    parameter int ADDR_W   = sigchg_pkg::SC_ADDR_W,
    localparam int TS_W    = $clog2(TS_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_valid,
    input  logic [TS_W-1:0]   sig_ts,
    input  logic [NIB_W-1:0]  sig_abcd,
    input  logic              mf_pulse,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq
);

    logic                chg_evt;
    logic [TS_COUNT-1:0] snapshot;

    sigchg_detect #(
        .TS_COUNT (TS_COUNT),
        .NIB_W    (NIB_W),
        .SKIP_A   (sigchg_pkg::SC_SKIP_TS_A),
        .SKIP_B   (sigchg_pkg::SC_SKIP_TS_B)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_valid (sig_valid),
        .sig_ts    (sig_ts),
        .sig_nib   (sig_abcd),
        .mf_pulse  (mf_pulse),
        .chg_evt   (chg_evt),
        .snapshot  (snapshot)
    );

    sigchg_regs #(
        .TS_COUNT (TS_COUNT),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .chg_evt    (chg_evt),
        .snapshot   (snapshot),
        .host_rdata (host_rdata),
        .irq        (irq)
    );

    AST_IRQ_AFTER_RST: assert property (@(posedge clk)
        !rst_n |=> !irq); // R10

endmodule

// File: tb/sigchg_irq_unit_tb.sv
module sigchg_irq_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_valid = 1'b0;
    logic [4:0] sig_ts = '0;
    logic [3:0] sig_abcd = '0;
    logic       mf_pulse = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    sigchg_irq_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_valid  (sig_valid),
        .sig_ts     (sig_ts),
        .sig_abcd   (sig_abcd),
        .mf_pulse   (mf_pulse),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .irq        (irq)
    );

    // Monitor: read data is due just after the edge that saw host_rd
    always @(posedge clk) begin : mon
        logic       due;
        logic [7:0] exp_v;
        string      tag_v;
        due = host_rd;
        #1;
        if (due) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with no expected item, got %02h", host_rdata);
            end else begin
                exp_v = exp_q.pop_front();
                tag_v = tag_q.pop_front();
                if (host_rdata !== exp_v) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %02h expected %02h", tag_v, host_rdata, exp_v);
                end
            end
        end
    end

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic send_sig(input logic [4:0] ts, input logic [3:0] nib);
        @(negedge clk);
        sig_valid = 1'b1; sig_ts = ts; sig_abcd = nib;
        @(negedge clk);
        sig_valid = 1'b0;
    endtask

    task automatic boundary();
        @(negedge clk);
        mf_pulse = 1'b1;
        @(negedge clk);
        mf_pulse = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        n_tests++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, e);
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        check_irq(1'b0, "R10");
        host_read(8'h00, 8'h00, "R10 blk_en");
        host_read(8'h04, 8'h00, "R10 status");
        host_read(8'h05, 8'h00, "R10 sig_en");
        host_read(8'h06, 8'h00, "R10 ctrl");
        for (int k = 0; k < 4; k++) host_read(8'h08 + 8'(k), 8'h00, "R10 snapshot");

        // R11: enables read back, unmapped reads 0
        host_write(8'h00, 8'h01);
        host_write(8'h05, 8'h01);
        host_read(8'h00, 8'h01, "R11 blk_en");
        host_read(8'h05, 8'h01, "R11 sig_en");
        host_read(8'h03, 8'h00, "R11 unmapped");

        // R1/R2/R3: one real change, one repeat, one unchanged, two skipped slots
        send_sig(5'd3, 4'h5);
        send_sig(5'd3, 4'h5);
        send_sig(5'd9, 4'h0);
        send_sig(5'd0, 4'hF);
        send_sig(5'd16, 4'hF);
        boundary();
        host_read(8'h08, 8'h08, "R1 ts3 flagged");
        host_read(8'h09, 8'h00, "R1 ts9 same nibble");
        host_read(8'h0A, 8'h00, "R2 ts16 ignored");
        host_read(8'h08, 8'h08, "R2 ts0 ignored");

        // R9/R5/R7: irq up, status holds across reads, write clears
        check_irq(1'b1, "R9 irq set");
        repeat (5) @(negedge clk);
        host_read(8'h04, 8'h01, "R7 read no clear");
        host_read(8'h04, 8'h01, "R5 status held");
        host_write(8'h04, 8'h01);
        host_read(8'h04, 8'h00, "R7 write clears");
        check_irq(1'b0, "R7 irq cleared");

        // R1/R3: repeated nibble gives nothing, window was cleared
        send_sig(5'd3, 4'h5);
        boundary();
        host_read(8'h08, 8'h00, "R3 window cleared");
        host_read(8'h04, 8'h00, "R1 repeat no status");

        // R3: change in the same cycle as the boundary lands in the new window
        @(negedge clk);
        sig_valid = 1'b1; sig_ts = 5'd20; sig_abcd = 4'hA; mf_pulse = 1'b1;
        @(negedge clk);
        sig_valid = 1'b0; mf_pulse = 1'b0;
        host_read(8'h0A, 8'h00, "R3 same-cycle not in old window");
        boundary();
        host_read(8'h0A, 8'h10, "R3 same-cycle in new window");
        host_write(8'h04, 8'h01);

        // R4: each enable alone blocks the status bit
        host_write(8'h05, 8'h00);
        send_sig(5'd5, 4'h1);
        host_read(8'h04, 8'h00, "R4 sig_en off");
        host_write(8'h05, 8'h01);
        host_write(8'h00, 8'h00);
        send_sig(5'd5, 4'h2);
        host_read(8'h04, 8'h00, "R4 blk_en off");
        check_irq(1'b0, "R4 irq off");

        // R9: block enable masks the line but keeps status
        host_write(8'h00, 8'h01);
        send_sig(5'd11, 4'h7);
        @(negedge clk);
        check_irq(1'b1, "R9 irq on");
        host_write(8'h00, 8'h00);
        @(negedge clk);
        check_irq(1'b0, "R9 blk off masks");
        host_read(8'h04, 8'h01, "R9 status kept");
        host_write(8'h00, 8'h01);
        @(negedge clk);
        check_irq(1'b1, "R9 irq back");
        host_write(8'h04, 8'h01);
        @(negedge clk);
        check_irq(1'b0, "R9 irq after clear");

        // R6: clear-on-read mode
        host_write(8'h06, 8'h01);
        host_read(8'h06, 8'h01, "R11 ctrl");
        send_sig(5'd12, 4'h9);
        host_write(8'h04, 8'h01);
        host_read(8'h04, 8'h01, "R6 write ignored");
        host_read(8'h04, 8'h00, "R6 read cleared");

        // R8: change in the same cycle as a clearing read
        send_sig(5'd7, 4'h3);
        exp_q.push_back(8'h01);
        tag_q.push_back("R8 read value");
        @(negedge clk);
        host_rd = 1'b1; host_addr = 8'h04;
        sig_valid = 1'b1; sig_ts = 5'd7; sig_abcd = 4'h6;
        @(negedge clk);
        host_rd = 1'b0; sig_valid = 1'b0;
        host_read(8'h04, 8'h01, "R8 set wins");
        host_read(8'h04, 8'h00, "R8 then cleared");

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule